// File: doc/BRIEF.md
# Vector Floating-Point Round-to-Integral Unit

This block rounds every lane of a packed vector of IEEE-754 values to an integral value, and keeps the result in the same floating-point format as the input. The lanes are half, single or double precision. The vector is 64 or 128 bits wide. The rounding direction is chosen for each operation by a two-bit mode input, so one datapath covers nearest-even rounding, floor, ceiling and truncation.

Each result lane is reported through two sticky-style flags for the whole operation. Inexact is set when a lane changed value. Invalid is set when a lane held a signaling NaN. An element size that has no legal lane layout is reported on a separate undefined-encoding output. In that case the result register is left untouched.

The unit has one register stage. An operand accepted with `in_valid` appears on the outputs on the next clock edge, together with `out_valid`.

Top module: `vfp_round_integral`

## Requirements
- R1: Each active lane is rounded to an integral value in its own format. The direction is set by `rmode`: 00 rounds to nearest with ties to even, 01 rounds toward plus infinity, 10 rounds toward minus infinity, 11 rounds toward zero.
- R2: `elem_size` 00 selects 16-bit lanes (10 fraction bits), 01 selects 32-bit lanes (23 fraction bits) and 10 selects 64-bit lanes (52 fraction bits). `wide`=1 selects a 128-bit vector and `wide`=0 selects a 64-bit vector. The lane count is the vector width divided by the element size, and lane i occupies bits [i*EW +: EW].
- R3: `flag_inexact` is 1 exactly when at least one active lane's result differs numerically from its input.
- R4: A zero lane returns the same zero, sign included, and an infinite lane returns the same infinity. Neither case sets any flag.
- R5: A signaling NaN (top fraction bit 0, fraction nonzero) is returned with the top fraction bit set and sets `flag_invalid`. A quiet NaN is returned unchanged and sets no flag.
- R6: With `dflt_nan`=1, every NaN lane is replaced by the canonical quiet NaN: sign 0, exponent all ones, only the top fraction bit set. Invalid still follows R5.
- R7: A nonzero lane with magnitude below one returns a zero or a one of its own sign, chosen by the mode, and sets inexact. A negative lane that rounds to zero returns negative zero.
- R8: A finite lane whose unbiased exponent is at least the fraction width is returned unchanged and does not set inexact.
- R9: Subnormal inputs are rounded by their true value, with no flushing to zero.
- R10: When `elem_size`=10 with `wide`=0, or when `elem_size`=11, an accepted operation sets `undef_enc`, clears both flags and leaves `result` at its previous value.
- R11: With `wide`=0 and a legal size, `result[127:64]` is zero. The upper operand bits have no effect on the result or the flags.
- R12: `out_valid` follows `in_valid` by one clock. `result`, the flags and `undef_enc` update only on accepted operations and otherwise hold. Synchronous reset clears all outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand and controls are valid this cycle |
| elem_size | input | 2 | Lane size select (00/01/10 legal, 11 undefined) |
| wide | input | 1 | 1 = 128-bit vector, 0 = 64-bit vector |
| rmode | input | 2 | Rounding direction |
| dflt_nan | input | 1 | Replace NaN results with the canonical quiet NaN |
| operand | input | 128 | Packed source lanes |
| out_valid | output | 1 | Registered result is valid this cycle |
| result | output | 128 | Packed integral lanes |
| flag_inexact | output | 1 | Some active lane changed value |
| flag_invalid | output | 1 | Some active lane was a signaling NaN |
| undef_enc | output | 1 | The last accepted size combination was illegal |

## Verification
The assertions assume that `in_valid`, `elem_size` and `wide` are known, non-X values in every cycle after reset, and that `in_valid` is low while reset is high. This matters because several properties infer the next-cycle outputs from these inputs. The stimulus drives every input to a defined value from time zero and holds `in_valid` low through reset. Random operands are shaped per lane so that exponents cluster around the integral boundary and the sub-one range, which exercises mixed-fraction rounding, ties and subnormals. The stimulus also includes occasional illegal size combinations and idle cycles.

// File: rtl/vfri_pkg.sv
package vfri_pkg;

    localparam int VEC_W = 128;

    typedef enum logic [1:0] {
        RM_NEAR_EVEN = 2'b00,
        RM_POS_INF   = 2'b01,
        RM_NEG_INF   = 2'b10,
        RM_TO_ZERO   = 2'b11
    } rnd_mode_e;

    typedef enum logic [1:0] {
        ES_HALF   = 2'b00,
        ES_SINGLE = 2'b01,
        ES_DOUBLE = 2'b10,
        ES_RSVD   = 2'b11
    } elem_size_e;

    typedef enum logic [2:0] {
        LC_NAN,
        LC_INF,
        LC_INTEGRAL,
        LC_ZERO,
        LC_SUBUNIT,
        LC_MIXED
    } lane_class_e;

    typedef struct packed {
        logic inexact;
        logic invalid;
    } fp_flags_t;

    function automatic int frac_bits(input int ew);
        return (ew == 16) ? 10 : (ew == 32) ? 23 : 52;
    endfunction

    function automatic int exp_bits(input int ew);
        return ew - frac_bits(ew) - 1;
    endfunction

endpackage

// File: rtl/vfri_lane.sv
module vfri_lane
    import vfri_pkg::*;
#(
    parameter int EW = 32
) (
    input  logic [EW-1:0] x,
    input  rnd_mode_e     rmode,
    input  logic          dflt_nan,
    output logic [EW-1:0] y,
    output fp_flags_t     flags
);

    localparam int FW   = frac_bits(EW);
    localparam int XW   = exp_bits(EW);
    localparam int BIAS = (1 << (XW - 1)) - 1;
    localparam int MW   = FW + 2;
    localparam logic [XW:0]   BIAS_W   = (XW+1)'(BIAS);
    localparam logic [XW:0]   INT_EDGE = (XW+1)'(BIAS + FW);
    localparam logic [XW-1:0] BIAS_E   = XW'(BIAS);
    localparam logic [XW-1:0] HALF_E   = XW'(BIAS - 1);
    localparam logic [FW-1:0] QBIT     = FW'(1) << (FW - 1);

    logic          sgn;
    logic [XW-1:0] ex;
    logic [FW-1:0] fr;
    assign {sgn, ex, fr} = x;

    lane_class_e cls;
    always_comb begin
        if (&ex)                         cls = (|fr) ? LC_NAN : LC_INF;
        else if ({1'b0, ex} >= INT_EDGE) cls = LC_INTEGRAL;
        else if ({1'b0, ex} < BIAS_W)    cls = (ex == '0 && fr == '0) ? LC_ZERO : LC_SUBUNIT;
        else                             cls = LC_MIXED;
    end

    // Mixed lanes: split the significand at the binary point.
    logic [XW:0]   k_amt;
    logic [MW-1:0] mant, unit, lowmask, half, drop, kept, sum;
    logic          odd, tie, above;
    always_comb begin
        k_amt   = INT_EDGE - {1'b0, ex};
        mant    = {2'b01, fr};
        unit    = MW'(1) << k_amt;
        lowmask = unit - MW'(1);
        half    = unit >> 1;
        drop    = mant & lowmask;
        kept    = mant & ~lowmask;
        odd     = |(kept & unit);
        tie     = (drop == half);
        above   = (drop > half);
        sum     = kept + unit;
    end

    logic sub_above, bump_mid, bump_sub;
    assign sub_above = (ex == HALF_E) && (fr != '0);

    always_comb begin
        case (rmode)
            RM_NEAR_EVEN: begin bump_mid = above || (tie && odd); bump_sub = sub_above; end
            RM_POS_INF:   begin bump_mid = !sgn && (|drop);       bump_sub = !sgn;      end
            RM_NEG_INF:   begin bump_mid = sgn && (|drop);        bump_sub = sgn;       end
            default:      begin bump_mid = 1'b0;                  bump_sub = 1'b0;      end
        endcase
    end

    always_comb begin
        y     = x;
        flags = '0;
        case (cls)
            LC_NAN: begin
                flags.invalid = !fr[FW-1];
                y = dflt_nan ? {1'b0, {XW{1'b1}}, QBIT} : {sgn, ex, fr | QBIT};
            end
            LC_SUBUNIT: begin
                flags.inexact = 1'b1;
                y = bump_sub ? {sgn, BIAS_E, {FW{1'b0}}} : {sgn, {(EW-1){1'b0}}};
            end
            LC_MIXED: begin
                flags.inexact = |drop;
                if (!bump_mid)         y = {sgn, ex, kept[FW-1:0]};
                else if (sum[MW-1])    y = {sgn, ex + XW'(1), {FW{1'b0}}};
                else                   y = {sgn, ex, sum[FW-1:0]};
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/vfri_lane_bank.sv
module vfri_lane_bank
    import vfri_pkg::*;
#(
    parameter int EW = 16,
    parameter int VW = VEC_W
) (
    input  logic [VW-1:0] vec_in,
    input  logic          narrow,
    input  rnd_mode_e     rmode,
    input  logic          dflt_nan,
    output logic [VW-1:0] vec_out,
    output logic          any_inexact,
    output logic          any_invalid
);

    localparam int NL    = VW / EW;
    localparam int NL_LO = NL / 2;

    logic [NL-1:0] act, ix_l, iv_l;

    for (genvar i = 0; i < NL; i++) begin : g_lane
        localparam bit LOWER = (i < NL_LO);
        logic [EW-1:0] y_l;
        fp_flags_t     f_l;

        vfri_lane #(.EW(EW)) u_lane (
            .x        (vec_in[i*EW +: EW]),
            .rmode    (rmode),
            .dflt_nan (dflt_nan),
            .y        (y_l),
            .flags    (f_l)
        );

        assign act[i]              = LOWER || !narrow;
        assign ix_l[i]             = f_l.inexact;
        assign iv_l[i]             = f_l.invalid;
        assign vec_out[i*EW +: EW] = act[i] ? y_l : '0;
    end

    assign any_inexact = |(ix_l & act);
    assign any_invalid = |(iv_l & act);

endmodule

// File: rtl/vfp_round_integral.sv
module vfp_round_integral
    import vfri_pkg::*;
#(
    parameter int VW = VEC_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [1:0]    elem_size,
    input  logic          wide,
    input  logic [1:0]    rmode,
    input  logic          dflt_nan,
    input  logic [VW-1:0] operand,
    output logic          out_valid,
    output logic [VW-1:0] result,
    output logic          flag_inexact,
    output logic          flag_invalid,
    output logic          undef_enc
);

    localparam int NB = 3;

    rnd_mode_e  rm;
    elem_size_e esz;
    assign rm  = rnd_mode_e'(rmode);
    assign esz = elem_size_e'(elem_size);

    logic [VW-1:0] bank_res [NB];
    logic [NB-1:0] bank_ix, bank_iv;

    for (genvar g = 0; g < NB; g++) begin : g_bank
        vfri_lane_bank #(.EW(16 << g), .VW(VW)) u_bank (
            .vec_in      (operand),
            .narrow      (!wide),
            .rmode       (rm),
            .dflt_nan    (dflt_nan),
            .vec_out     (bank_res[g]),
            .any_inexact (bank_ix[g]),
            .any_invalid (bank_iv[g])
        );
    end

    logic          illegal, pick_ix, pick_iv;
    logic [VW-1:0] pick_res;
    always_comb begin
        illegal  = 1'b0;
        pick_res = bank_res[0];
        pick_ix  = bank_ix[0];
        pick_iv  = bank_iv[0];
        case (esz)
            ES_HALF: ;
            ES_SINGLE: begin
                pick_res = bank_res[1];
                pick_ix  = bank_ix[1];
                pick_iv  = bank_iv[1];
            end
            ES_DOUBLE: begin
                pick_res = bank_res[2];
                pick_ix  = bank_ix[2];
                pick_iv  = bank_iv[2];
                illegal  = !wide;
            end
            default: illegal = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid    <= 1'b0;
            result       <= '0;
            flag_inexact <= 1'b0;
            flag_invalid <= 1'b0;
            undef_enc    <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                undef_enc <= illegal;
                if (illegal) begin
                    flag_inexact <= 1'b0;
                    flag_invalid <= 1'b0;
                end else begin
                    result       <= pick_res;
                    flag_inexact <= pick_ix;
                    flag_invalid <= pick_iv;
                end
            end
        end
    end

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);                                            // R12

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid && $stable(result) && $stable(flag_inexact)); // R12

    AST_UNDEF_KEEPS_RESULT: assert property (@(posedge clk) disable iff (rst)
        in_valid && (elem_size == 2'b11) |=> $stable(result) && !flag_inexact && !flag_invalid); // R10

    AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        in_valid && !wide && (elem_size[1] == 1'b0) |=> result[VW-1:VW/2] == '0); // R11

    AST_ZERO_IS_EXACT: assert property (@(posedge clk) disable iff (rst)
        in_valid && (operand == '0) && (elem_size != 2'b11) && (wide || elem_size != 2'b10)
        |=> (result == '0) && !flag_inexact && !flag_invalid);               // R4

endmodule

// File: tb/tb_vfp_round_integral.sv
`timescale 1ns/1ps
module tb_vfp_round_integral;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [1:0]   elem_size = 2'b00;
    logic         wide = 1'b1;
    logic [1:0]   rmode = 2'b00;
    logic         dflt_nan = 1'b0;
    logic [127:0] operand = '0;
    logic         out_valid, flag_inexact, flag_invalid, undef_enc;
    logic [127:0] result;

    int checks = 0;
    int failures = 0;
    bit finished = 0;
    logic [127:0] last_res = '0;

    always #2 clk = ~clk;

    vfp_round_integral dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .elem_size(elem_size),
        .wide(wide), .rmode(rmode), .dflt_nan(dflt_nan), .operand(operand),
        .out_valid(out_valid), .result(result), .flag_inexact(flag_inexact),
        .flag_invalid(flag_invalid), .undef_enc(undef_enc)
    );

    function automatic int fw_of(input int ew);
        return (ew == 16) ? 10 : (ew == 32) ? 23 : 52;
    endfunction

    // Reference rounding of one lane by integer part and remainder.
    function automatic logic [63:0] ref_lane(input int ew, input logic [63:0] x,
                                             input logic [1:0] rm, input logic dn,
                                             output logic ix, output logic iv);
        int fw, exw, bias, k, p;
        logic [63:0] e, f, m, ip, r, hf, n, maxe, fmask;
        logic s, up;
        fw = fw_of(ew);
        exw = ew - fw - 1;
        bias = (1 << (exw - 1)) - 1;
        maxe = (64'd1 << exw) - 1;
        fmask = (64'd1 << fw) - 1;
        ix = 1'b0; iv = 1'b0;
        s = x[ew-1];
        e = (x >> fw) & maxe;
        f = x & fmask;
        if (e == maxe) begin
            if (f == 0) return x;
            iv = !f[fw-1];
            if (dn) return (maxe << fw) | (64'd1 << (fw - 1));
            return x | (64'd1 << (fw - 1));
        end
        if (e == 0 && f == 0) return x;
        if (e >= 64'(bias + fw)) return x;
        ix = 1'b1;
        if (e < 64'(bias)) begin
            case (rm)
                2'b00: up = (e == 64'(bias - 1)) && (f != 0);
                2'b01: up = !s;
                2'b10: up = s;
                default: up = 1'b0;
            endcase
            return (64'(s) << (ew - 1)) | (up ? (64'(bias) << fw) : 64'd0);
        end
        k = bias + fw - int'(e);
        m = (64'd1 << fw) | f;
        ip = m >> k;
        r = m & ((64'd1 << k) - 1);
        hf = 64'd1 << (k - 1);
        ix = (r != 0);
        case (rm)
            2'b00: up = (r > hf) || (r == hf && ip[0]);
            2'b01: up = !s && (r != 0);
            2'b10: up = s && (r != 0);
            default: up = 1'b0;
        endcase
        n = ip + 64'(up);
        p = 0;
        for (int b = 0; b < 64; b++) if (n[b]) p = b;
        return (64'(s) << (ew - 1)) | (64'(bias + p) << fw) | ((n << (fw - p)) & fmask);
    endfunction

    function automatic logic [127:0] ref_vec(input logic [1:0] es, input logic wd,
                                             input logic [1:0] rm, input logic dn,
                                             input logic [127:0] op,
                                             output logic ix, output logic iv);
        int ew, nl;
        logic [127:0] res;
        logic lx, lv;
        logic [63:0] ln, lmask;
        ew = 16 << es;
        nl = (wd ? 128 : 64) / ew;
        lmask = (ew == 64) ? '1 : ((64'd1 << ew) - 1);
        res = '0; ix = 1'b0; iv = 1'b0;
        for (int i = 0; i < nl; i++) begin
            ln = 64'(op >> (i * ew)) & lmask;
            ln = ref_lane(ew, ln, rm, dn, lx, lv);
            res = res | (128'(ln) << (i * ew));
            ix = ix | lx;
            iv = iv | lv;
        end
        return res;
    endfunction

    task automatic check_bit(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic check_vec(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Apply one operation, then check outputs one cycle later.
    task automatic run_op(input string tag, input logic [1:0] es, input logic wd,
                          input logic [1:0] rm, input logic dn, input logic [127:0] op);
        logic ex_ix, ex_iv, ex_ud;
        logic [127:0] ex_res;
        ex_ud = (es == 2'b11) || (es == 2'b10 && !wd);
        if (ex_ud) begin
            ex_res = last_res; ex_ix = 1'b0; ex_iv = 1'b0;
        end else begin
            ex_res = ref_vec(es, wd, rm, dn, op, ex_ix, ex_iv);
        end
        @(negedge clk);
        elem_size = es; wide = wd; rmode = rm; dflt_nan = dn; operand = op;
        in_valid = 1'b1;
        @(posedge clk);
        #1;
        check_bit({tag, " out_valid R12"}, out_valid, 1'b1);
        check_vec({tag, " result R1"}, result, ex_res);
        check_bit({tag, " inexact R3"}, flag_inexact, ex_ix);
        check_bit({tag, " invalid R5"}, flag_invalid, ex_iv);
        check_bit({tag, " undef R10"}, undef_enc, ex_ud);
        last_res = ex_res;
    endtask

    task automatic idle_check();
        @(negedge clk);
        in_valid = 1'b0;
        operand = {4{$urandom()}};
        @(posedge clk);
        #1;
        check_bit("idle out_valid R12", out_valid, 1'b0);
        check_vec("idle hold R12", result, last_res);
    endtask

    function automatic logic [127:0] shape_op(input logic [1:0] es);
        int ew, fw, exw, bias, sel;
        logic [127:0] op;
        logic [63:0] ln, emask;
        ew = 16 << ((es == 2'b11) ? 2'b00 : es);
        fw = fw_of(ew);
        exw = ew - fw - 1;
        bias = (1 << (exw - 1)) - 1;
        emask = ((64'd1 << exw) - 1) << fw;
        op = {$urandom(), $urandom(), $urandom(), $urandom()};
        for (int i = 0; i < 128 / ew; i++) begin
            ln = 64'(op >> (i * ew));
            sel = int'($urandom_range(0, 9));
            if (sel < 6)
                ln = (ln & ~emask) | ((64'(bias - 2 + int'($urandom_range(0, fw + 3)))) << fw);
            else if (sel == 6)
                ln = ln & ~emask;
            else if (sel == 7)
                ln = ln | emask;
            if (ew < 64) ln = ln & ((64'd1 << ew) - 1);
            op = (op & ~(128'((ew == 64) ? '1 : ((64'd1 << ew) - 1)) << (i * ew)))
                 | (128'(ln) << (i * ew));
        end
        return op;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1f2e3d4c));
        repeat (3) @(posedge clk);
        #1;
        check_bit("reset out_valid R12", out_valid, 1'b0);
        check_vec("reset result R12", result, '0);
        check_bit("reset flags R12", flag_inexact | flag_invalid | undef_enc, 1'b0);
        @(negedge clk);
        rst = 1'b0;

        // R1: 2.5 half nearest-even -> 2.0, 3.5 -> 4.0
        run_op("half ties R1", 2'b00, 1'b1, 2'b00, 1'b0, 128'h4300_4100);
        check_vec("half ties literal R1", result, 128'h4400_4000);
        // R7: -0.3 toward +inf -> -0; -0.5 toward -inf -> -1; 0.5 nearest -> +0
        run_op("subunit R7", 2'b00, 1'b1, 2'b01, 1'b0, 128'hB4CD);
        check_vec("neg zero R7", result, 128'h8000);
        run_op("subunit down R7", 2'b00, 1'b1, 2'b10, 1'b0, 128'h3800_B800);
        check_vec("down literal R7", result, 128'h0000_BC00);
        run_op("half nearest R7", 2'b00, 1'b1, 2'b00, 1'b0, 128'h3800);
        check_vec("half to zero R7", result, 128'h0);
        // R5 / R6: single NaNs
        run_op("snan R5", 2'b01, 1'b1, 2'b00, 1'b0, 128'h7FC0_0002_7F80_0001);
        check_vec("snan quiet R5", result, 128'h7FC0_0002_7FC0_0001);
        run_op("dnan R6", 2'b01, 1'b1, 2'b11, 1'b1, 128'hFF80_0001);
        check_vec("dnan canon R6", result, 128'h7FC0_0000);
        // R4: infinities and signed zeros, double lanes
        run_op("inf zero R4", 2'b10, 1'b1, 2'b01, 1'b0, 128'hFFF0_0000_0000_0000_8000_0000_0000_0000);
        check_bit("inf zero exact R4", flag_inexact, 1'b0);
        // R8: already integral single 2^23 + 1
        run_op("big R8", 2'b01, 1'b1, 2'b10, 1'b0, 128'h4B00_0001);
        check_vec("big unchanged R8", result, 128'h4B00_0001);
        // R9: double subnormal toward +inf -> 1.0
        run_op("subnormal R9", 2'b10, 1'b1, 2'b01, 1'b0, 128'h1);
        check_vec("subnormal one R9", result, 128'h3FF0_0000_0000_0000);
        // R10: illegal sizes keep result
        run_op("undef double R10", 2'b10, 1'b0, 2'b00, 1'b0, {4{32'h7F80_0001}});
        run_op("undef rsvd R10", 2'b11, 1'b1, 2'b00, 1'b0, {4{32'h3F40_0000}});
        // R11: narrow ignores upper half (upper holds signaling NaNs)
        run_op("narrow R11", 2'b01, 1'b0, 2'b00, 1'b0, {64'h7F80_0001_7F80_0001, 64'h3F80_0000_4000_0000});
        check_vec("narrow upper R11", result, {64'h0, 64'h3F80_0000_4000_0000});
        check_bit("narrow flag R11", flag_invalid, 1'b0);
        // R2: lane placement in single and half narrow
        run_op("narrow half R2", 2'b00, 1'b0, 2'b11, 1'b0, {64'hFFFF_FFFF_FFFF_FFFF, 64'h3E00_4500_C500_4700});
        idle_check();

        for (int t = 0; t < 1500; t++) begin
            logic [1:0] es;
            es = 2'($urandom_range(0, 3));
            if ($urandom_range(0, 9) != 0 && es == 2'b11) es = 2'b01;
            run_op("random R1 R2 R3", es, 1'($urandom()), 2'($urandom()), 1'($urandom()), shape_op(es));
            if ($urandom_range(0, 15) == 0) idle_check();
        end

        finished = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule